// File: doc/BRIEF.md
# Host I/O Cycle Decode Router

This block receives I/O read and write requests issued by the processor and sends each one to exactly one destination. The four destinations are the host bridge's own configuration-access port pair, an internal graphics function, a PCI Express port and the default downstream hub link. Routing follows a fixed priority. The configuration ports come first. Graphics comes next when it is enabled and its programmable address match hits. The PCI Express I/O window follows, when it is enabled and the address page lies between its base and limit. Every other access goes to the hub link. The 16-bit address is forwarded unchanged. The block adds a 17th bit that is set whenever the access runs past the top of the I/O space.

I/O cycles are non-posted, so the router holds a single request at a time. It keeps the one-hot destination select and the request fields steady until the destination signals done. It then returns one completion to the processor. That completion carries the read data and a status flag that marks either success or Unsupported Request.

A second, independent path handles requests that arrive upstream from the downstream links. Memory requests pass through unchanged. I/O and configuration requests are illegal in that direction. The block rewrites each of them as a memory read of address zero and flags it so that its completion returns Unsupported Request status.

Top module: `hio_route_top`

## Requirements
- R1: After synchronous reset, `cpu_req_ready` is 1 and `dst_valid`, `cpu_cpl_valid` and `mem_req_valid` are 0.
- R2: `dst_addr[16]` is 1 exactly when the access runs past 0xFFFF. Sizes are encoded as `cpu_req_size` 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved (treated as 1 byte). The bit is therefore set for 4 bytes at 0xFFFD, 0xFFFE or 0xFFFF and for 2 bytes at 0xFFFF, and clear otherwise.
- R3: `dst_addr[15:0]`, `dst_write`, `dst_size`, `dst_be` and `dst_wdata` equal the accepted request's fields, with no translation.
- R4: A start address in 0x0CF8..0x0CFF selects the configuration ports (`dst_sel` = 4'b0001), whatever the graphics and window settings are.
- R5: If R4 does not apply, `gfx_en` is 1 and `(addr & gfx_mask) == (gfx_base & gfx_mask)`, graphics is selected (`dst_sel` = 4'b0010), even when the address also lies in the PCI Express window. With `gfx_en` 0, graphics is never selected.
- R6: If neither R4 nor R5 applies, `win_en` is 1 and `win_base <= addr[15:12] <= win_limit` (4 KB pages), the PCI Express port is selected (`dst_sel` = 4'b0100). With `win_base > win_limit` the window is empty.
- R7: Every other access selects the hub link (`dst_sel` = 4'b1000). While `dst_valid` is 1, `dst_sel` is one-hot.
- R8: A request is accepted at a clock edge where `cpu_req_valid` and `cpu_req_ready` are both 1. From the next cycle until the edge where `dst_done` is sampled, `dst_valid` is 1, `cpu_req_ready` is 0 and the destination fields stay stable. Requests presented in that time are ignored.
- R9: `cpu_cpl_valid` pulses for one cycle, in the cycle after `dst_done` is sampled. For reads, `cpu_cpl_rdata` carries `dst_rdata`; for writes it is 0. `cpu_cpl_ur` copies `dst_ur` (0 = success, 1 = Unsupported Request).
- R10: One cycle after `up_req_valid` is sampled, `mem_req_valid` is 1. `up_req_kind` is encoded as 0 = memory read, 1 = memory write, 2 = I/O, 3 = configuration. Kinds 2 and 3 produce a read (`mem_req_write` 0) of address 0 with `mem_req_ur` 1. Kinds 0 and 1 pass through the address and direction with `mem_req_ur` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor I/O request present |
| cpu_req_ready | output | 1 | Router can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 16 | I/O start address |
| cpu_req_size | input | 2 | Access size code |
| cpu_req_be | input | 4 | Byte enables |
| cpu_req_wdata | input | 32 | Write data |
| cpu_cpl_valid | output | 1 | Completion pulse to processor |
| cpu_cpl_rdata | output | 32 | Completion read data |
| cpu_cpl_ur | output | 1 | Completion is Unsupported Request |
| gfx_en | input | 1 | Graphics I/O claim enable |
| gfx_base | input | 16 | Graphics match value |
| gfx_mask | input | 16 | Graphics match mask |
| win_en | input | 1 | PCI Express window enable |
| win_base | input | 4 | Window first 4 KB page |
| win_limit | input | 4 | Window last 4 KB page |
| dst_valid | output | 1 | Request held toward destination |
| dst_sel | output | 4 | One-hot destination select |
| dst_write | output | 1 | Forwarded direction |
| dst_addr | output | 17 | Forwarded address with wrap bit 16 |
| dst_size | output | 2 | Forwarded size code |
| dst_be | output | 4 | Forwarded byte enables |
| dst_wdata | output | 32 | Forwarded write data |
| dst_done | input | 1 | Selected destination has completed |
| dst_rdata | input | 32 | Destination read data |
| dst_ur | input | 1 | Destination status, 1 = Unsupported Request |
| up_req_valid | input | 1 | Upstream request present |
| up_req_kind | input | 2 | Upstream request kind |
| up_req_addr | input | 32 | Upstream request address |
| mem_req_valid | output | 1 | Converted memory request |
| mem_req_write | output | 1 | Converted direction |
| mem_req_addr | output | 32 | Converted address |
| mem_req_ur | output | 1 | Completion must report Unsupported Request |

## Verification
The assertions assume that `dst_done` is raised only while `dst_valid` is 1. They also assume that the window and graphics settings do not change while a request is held. The bench changes those settings only when the router is idle, and it raises `dst_done` only in a cycle where it has already seen `dst_valid` high. The upstream path assumes nothing about its inputs, because it registers every sample.

// File: rtl/hio_route_pkg.sv
package hio_route_pkg;

    parameter int unsigned IO_AW   = 16;
    parameter int unsigned IO_DW   = 32;
    parameter int unsigned IO_BEW  = IO_DW / 8;
    parameter int unsigned PAGE_W  = 12;
    parameter int unsigned WIN_W   = IO_AW - PAGE_W;
    parameter int unsigned UP_AW   = 32;

    typedef enum logic [1:0] {
        SZ_1   = 2'd0,
        SZ_2   = 2'd1,
        SZ_4   = 2'd2,
        SZ_RSV = 2'd3
    } io_size_e;

    typedef enum logic [3:0] {
        DST_CFG  = 4'b0001,
        DST_GFX  = 4'b0010,
        DST_PCIE = 4'b0100,
        DST_HUB  = 4'b1000
    } dest_e;

    typedef enum logic [1:0] {
        UK_MEM_RD = 2'd0,
        UK_MEM_WR = 2'd1,
        UK_IO     = 2'd2,
        UK_CFG    = 2'd3
    } up_kind_e;

    typedef struct packed {
        logic              write;
        logic [IO_AW:0]    addr;
        io_size_e          size;
        logic [IO_BEW-1:0] be;
        logic [IO_DW-1:0]  wdata;
    } io_req_t;

    function automatic logic [1:0] size_span(input io_size_e sz);
        case (sz)
            SZ_2:    return 2'd1;
            SZ_4:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/hio_wrap_calc.sv
module hio_wrap_calc
    import hio_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IO_AW-1:0] addr,
    input  io_size_e         size,
    output logic             wrap
);
    localparam logic [IO_AW-1:0] TOP_FIRST = {IO_AW{1'b1}} - 2;

    logic [IO_AW:0] last_byte;

    always_comb begin
        last_byte = {1'b0, addr} + {{(IO_AW-1){1'b0}}, size_span(size)};
        wrap      = last_byte[IO_AW];
    end

    AST_WRAP_TOP_ONLY: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (addr >= TOP_FIRST)); // R2

endmodule

// File: rtl/hio_dest_decode.sv
module hio_dest_decode
    import hio_route_pkg::*;
#(
    parameter logic [IO_AW-1:0] CFG_BASE = 16'h0CF8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IO_AW-1:0] addr,
    input  logic             gfx_en,
    input  logic [IO_AW-1:0] gfx_base,
    input  logic [IO_AW-1:0] gfx_mask,
    input  logic             win_en,
    input  logic [WIN_W-1:0] win_base,
    input  logic [WIN_W-1:0] win_limit,
    output dest_e            dest
);
    localparam int unsigned CFG_LSB = 3;

    logic             hit_cfg;
    logic             hit_gfx;
    logic             hit_win;
    logic [WIN_W-1:0] page;

    always_comb begin
        page    = addr[IO_AW-1:PAGE_W];
        hit_cfg = (addr[IO_AW-1:CFG_LSB] == CFG_BASE[IO_AW-1:CFG_LSB]);
        hit_gfx = gfx_en && ((addr & gfx_mask) == (gfx_base & gfx_mask));
        hit_win = win_en && (page >= win_base) && (page <= win_limit);
        if (hit_cfg)      dest = DST_CFG;
        else if (hit_gfx) dest = DST_GFX;
        else if (hit_win) dest = DST_PCIE;
        else              dest = DST_HUB;
    end

    AST_GFX_OFF_NEVER: assert property (@(posedge clk) disable iff (rst)
        !gfx_en |-> (dest != DST_GFX)); // R5
    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (win_base > win_limit) |-> (dest != DST_PCIE)); // R6

endmodule

// File: rtl/hio_upstream_conv.sv
module hio_upstream_conv
    import hio_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             up_req_valid,
    input  up_kind_e         up_req_kind,
    input  logic [UP_AW-1:0] up_req_addr,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic [UP_AW-1:0] mem_req_addr,
    output logic             mem_req_ur
);
    logic illegal;

    always_comb illegal = (up_req_kind == UK_IO) || (up_req_kind == UK_CFG);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req_valid <= 1'b0;
            mem_req_write <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_ur    <= 1'b0;
        end else begin
            mem_req_valid <= up_req_valid;
            if (up_req_valid) begin
                if (illegal) begin
                    mem_req_write <= 1'b0;
                    mem_req_addr  <= '0;
                    mem_req_ur    <= 1'b1;
                end else begin
                    mem_req_write <= (up_req_kind == UK_MEM_WR);
                    mem_req_addr  <= up_req_addr;
                    mem_req_ur    <= 1'b0;
                end
            end
        end
    end

    AST_UP_ILLEGAL_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (up_req_valid && up_req_kind[1]) |=>
            (mem_req_valid && mem_req_ur && !mem_req_write && (mem_req_addr == '0))); // R10

endmodule

// File: rtl/hio_route_top.sv
module hio_route_top
    import hio_route_pkg::*;
#(
    parameter logic [IO_AW-1:0] CFG_BASE = 16'h0CF8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [IO_AW-1:0]  cpu_req_addr,
    input  logic [1:0]        cpu_req_size,
    input  logic [IO_BEW-1:0] cpu_req_be,
    input  logic [IO_DW-1:0]  cpu_req_wdata,
    output logic              cpu_cpl_valid,
    output logic [IO_DW-1:0]  cpu_cpl_rdata,
    output logic              cpu_cpl_ur,
    input  logic              gfx_en,
    input  logic [IO_AW-1:0]  gfx_base,
    input  logic [IO_AW-1:0]  gfx_mask,
    input  logic              win_en,
    input  logic [WIN_W-1:0]  win_base,
    input  logic [WIN_W-1:0]  win_limit,
    output logic              dst_valid,
    output logic [3:0]        dst_sel,
    output logic              dst_write,
    output logic [IO_AW:0]    dst_addr,
    output logic [1:0]        dst_size,
    output logic [IO_BEW-1:0] dst_be,
    output logic [IO_DW-1:0]  dst_wdata,
    input  logic              dst_done,
    input  logic [IO_DW-1:0]  dst_rdata,
    input  logic              dst_ur,
    input  logic              up_req_valid,
    input  logic [1:0]        up_req_kind,
    input  logic [UP_AW-1:0]  up_req_addr,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [UP_AW-1:0]  mem_req_addr,
    output logic              mem_req_ur
);
    io_size_e size_in;
    logic     wrap_in;
    dest_e    dest_in;
    io_req_t  req_d;
    io_req_t  req_q;
    dest_e    dest_q;
    logic     busy;

    always_comb size_in = io_size_e'(cpu_req_size);

    hio_wrap_calc u_wrap (
        .clk  (clk),
        .rst  (rst),
        .addr (cpu_req_addr),
        .size (size_in),
        .wrap (wrap_in)
    );

    hio_dest_decode #(.CFG_BASE(CFG_BASE)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .addr      (cpu_req_addr),
        .gfx_en    (gfx_en),
        .gfx_base  (gfx_base),
        .gfx_mask  (gfx_mask),
        .win_en    (win_en),
        .win_base  (win_base),
        .win_limit (win_limit),
        .dest      (dest_in)
    );

    hio_upstream_conv u_upconv (
        .clk           (clk),
        .rst           (rst),
        .up_req_valid  (up_req_valid),
        .up_req_kind   (up_kind_e'(up_req_kind)),
        .up_req_addr   (up_req_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ur    (mem_req_ur)
    );

    always_comb begin
        req_d.write = cpu_req_write;
        req_d.addr  = {wrap_in, cpu_req_addr};
        req_d.size  = size_in;
        req_d.be    = cpu_req_be;
        req_d.wdata = cpu_req_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy          <= 1'b0;
            req_q         <= '0;
            dest_q        <= DST_HUB;
            cpu_cpl_valid <= 1'b0;
            cpu_cpl_rdata <= '0;
            cpu_cpl_ur    <= 1'b0;
        end else begin
            cpu_cpl_valid <= 1'b0;
            if (!busy) begin
                if (cpu_req_valid) begin
                    busy   <= 1'b1;
                    req_q  <= req_d;
                    dest_q <= dest_in;
                end
            end else if (dst_done) begin
                busy          <= 1'b0;
                cpu_cpl_valid <= 1'b1;
                cpu_cpl_rdata <= req_q.write ? '0 : dst_rdata;
                cpu_cpl_ur    <= dst_ur;
            end
        end
    end

    always_comb begin
        cpu_req_ready = !busy;
        dst_valid     = busy;
        dst_sel       = dest_q;
        dst_write     = req_q.write;
        dst_addr      = req_q.addr;
        dst_size      = req_q.size;
        dst_be        = req_q.be;
        dst_wdata     = req_q.wdata;
    end

    AST_SEL_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        dst_valid |-> ($countones(dst_sel) == 1)); // R7
    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && !dst_done) |=>
            (dst_valid && $stable(dst_addr) && $stable(dst_sel) && $stable(dst_wdata))); // R8
    AST_CPL_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && dst_done) |=> (cpu_cpl_valid && !dst_valid)); // R9
    AST_CFG_WINS: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && (dst_addr[IO_AW-1:3] == CFG_BASE[IO_AW-1:3])) |->
            (dst_sel == DST_CFG)); // R4

endmodule

// File: tb/hio_route_top_bench.sv
module hio_route_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req_valid, cpu_req_ready, cpu_req_write;
    logic [15:0] cpu_req_addr;
    logic [1:0]  cpu_req_size;
    logic [3:0]  cpu_req_be;
    logic [31:0] cpu_req_wdata;
    logic        cpu_cpl_valid, cpu_cpl_ur;
    logic [31:0] cpu_cpl_rdata;
    logic        gfx_en;
    logic [15:0] gfx_base, gfx_mask;
    logic        win_en;
    logic [3:0]  win_base, win_limit;
    logic        dst_valid, dst_write;
    logic [3:0]  dst_sel;
    logic [16:0] dst_addr;
    logic [1:0]  dst_size;
    logic [3:0]  dst_be;
    logic [31:0] dst_wdata;
    logic        dst_done, dst_ur;
    logic [31:0] dst_rdata;
    logic        up_req_valid;
    logic [1:0]  up_req_kind;
    logic [31:0] up_req_addr;
    logic        mem_req_valid, mem_req_write, mem_req_ur;
    logic [31:0] mem_req_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    hio_route_top u_hio_route_top (.*);

    typedef struct packed {
        logic [15:0] a;
        logic [1:0]  sz;
        logic [3:0]  sel;
        logic        wrap;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{16'h0CF8, 2'd2, 4'b0001, 1'b0},
        '{16'h0CFE, 2'd0, 4'b0001, 1'b0},
        '{16'h03C4, 2'd1, 4'b0010, 1'b0},
        '{16'h03DF, 2'd0, 4'b0010, 1'b0},
        '{16'h03E0, 2'd0, 4'b1000, 1'b0},
        '{16'h4000, 2'd2, 4'b0100, 1'b0},
        '{16'h7FFF, 2'd0, 4'b0100, 1'b0},
        '{16'h8000, 2'd2, 4'b1000, 1'b0},
        '{16'hFFFD, 2'd2, 4'b1000, 1'b1},
        '{16'hFFFF, 2'd1, 4'b1000, 1'b1},
        '{16'hFFFE, 2'd1, 4'b1000, 1'b0},
        '{16'hFFFC, 2'd2, 4'b1000, 1'b0},
        '{16'hFFFF, 2'd3, 4'b1000, 1'b0}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string sel_tag(input logic [3:0] s);
        case (s)
            4'b0001: return "R4";
            4'b0010: return "R5";
            4'b0100: return "R6";
            default: return "R7";
        endcase
    endfunction

    // present a request, check the held destination fields
    task automatic start_io(input logic [15:0] a, input logic [1:0] sz, input logic wr,
                            input logic [3:0] sel, input logic wrap);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_addr = a; cpu_req_size = sz;
        cpu_req_write = wr; cpu_req_be = 4'hA ^ a[3:0]; cpu_req_wdata = {a, 16'h5A5A};
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(dst_valid && !cpu_req_ready, "R8", {30'd0, dst_valid, cpu_req_ready}, 32'h2);
        chk(dst_sel == sel, sel_tag(sel), {28'd0, dst_sel}, {28'd0, sel});
        chk(dst_addr[16] == wrap, "R2", {31'd0, dst_addr[16]}, {31'd0, wrap});
        chk(dst_addr[15:0] == a && dst_write == wr && dst_size == sz &&
            dst_be == (4'hA ^ a[3:0]) && dst_wdata == {a, 16'h5A5A}, "R3",
            {15'd0, dst_addr}, {16'd0, a});
    endtask

    task automatic finish_io(input logic wr, input logic [31:0] rd, input logic ur);
        dst_done = 1'b1; dst_rdata = rd; dst_ur = ur;
        @(negedge clk);
        dst_done = 1'b0;
        chk(cpu_cpl_valid && !dst_valid, "R9", {31'd0, cpu_cpl_valid}, 32'd1);
        chk(cpu_cpl_rdata == (wr ? 32'd0 : rd), "R9", cpu_cpl_rdata, wr ? 32'd0 : rd);
        chk(cpu_cpl_ur == ur, "R9", {31'd0, cpu_cpl_ur}, {31'd0, ur});
        @(negedge clk);
        chk(!cpu_cpl_valid, "R9", {31'd0, cpu_cpl_valid}, 32'd0);
    endtask

    task automatic up_case(input logic [1:0] k, input logic [31:0] a,
                           input logic ew, input logic [31:0] ea, input logic eu);
        @(negedge clk);
        up_req_valid = 1'b1; up_req_kind = k; up_req_addr = a;
        @(negedge clk);
        up_req_valid = 1'b0;
        chk(mem_req_valid && mem_req_write == ew && mem_req_addr == ea && mem_req_ur == eu,
            "R10", mem_req_addr, ea);
        @(negedge clk);
        chk(!mem_req_valid, "R10", {31'd0, mem_req_valid}, 32'd0);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst = 1'b1; cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = 0;
        cpu_req_size = 0; cpu_req_be = 0; cpu_req_wdata = 0;
        gfx_en = 1'b1; gfx_base = 16'h03C0; gfx_mask = 16'hFFE0;
        win_en = 1'b1; win_base = 4'h4; win_limit = 4'h7;
        dst_done = 0; dst_rdata = 0; dst_ur = 0;
        up_req_valid = 0; up_req_kind = 0; up_req_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(cpu_req_ready && !dst_valid && !cpu_cpl_valid && !mem_req_valid, "R1",
            {28'd0, cpu_req_ready, dst_valid, cpu_cpl_valid, mem_req_valid}, 32'h8);

        for (int i = 0; i < NV; i++) begin
            start_io(VEC[i].a, VEC[i].sz, i[0], VEC[i].sel, VEC[i].wrap);
            finish_io(i[0], 32'hC0DE_0000 + i, i[1]);
        end

        // R5 graphics disabled falls through to hub
        gfx_en = 1'b0;
        start_io(16'h03C4, 2'd0, 1'b0, 4'b1000, 1'b0);
        finish_io(1'b0, 32'h1111_2222, 1'b0);
        // R5 graphics beats the PCI Express window
        gfx_en = 1'b1; gfx_base = 16'h5000; gfx_mask = 16'hFFF0;
        start_io(16'h5004, 2'd1, 1'b0, 4'b0010, 1'b0);
        finish_io(1'b0, 32'h3333_4444, 1'b0);
        // R4 config beats an overlapping graphics match
        gfx_base = 16'h0CF8; gfx_mask = 16'hFFF8;
        start_io(16'h0CFC, 2'd2, 1'b1, 4'b0001, 1'b0);
        finish_io(1'b1, 32'hFFFF_FFFF, 1'b0);
        // R6 empty window when base > limit, and window disable
        gfx_en = 1'b0; win_base = 4'h8; win_limit = 4'h5;
        start_io(16'h6000, 2'd0, 1'b0, 4'b1000, 1'b0);
        finish_io(1'b0, 32'h0, 1'b1);
        win_base = 4'h6; win_limit = 4'h6;
        start_io(16'h6FFF, 2'd0, 1'b0, 4'b0100, 1'b0);
        finish_io(1'b0, 32'h7, 1'b0);
        win_en = 1'b0;
        start_io(16'h6000, 2'd0, 1'b0, 4'b1000, 1'b0);
        finish_io(1'b0, 32'h8, 1'b0);

        // R8 request presented while busy is ignored, fields stay stable
        win_en = 1'b1;
        start_io(16'h8000, 2'd2, 1'b1, 4'b1000, 1'b0);
        cpu_req_valid = 1'b1; cpu_req_addr = 16'h6000; cpu_req_write = 1'b0;
        repeat (2) @(negedge clk);
        chk(dst_addr == 17'h08000 && dst_sel == 4'b1000 && !cpu_req_ready, "R8",
            {15'd0, dst_addr}, 32'h8000);
        cpu_req_valid = 1'b0;
        finish_io(1'b1, 32'h9, 1'b0);
        chk(!dst_valid && cpu_req_ready, "R8", {31'd0, dst_valid}, 32'd0);

        // R10 upstream conversion
        up_case(2'd2, 32'h0000_1234, 1'b0, 32'd0, 1'b1);
        up_case(2'd3, 32'h8000_0010, 1'b0, 32'd0, 1'b1);
        up_case(2'd1, 32'h0010_0000, 1'b1, 32'h0010_0000, 1'b0);
        up_case(2'd0, 32'hFEE0_0004, 1'b0, 32'hFEE0_0004, 1'b0);

        // R1 reset in mid-transaction returns to idle
        start_io(16'h9000, 2'd0, 1'b0, 4'b1000, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(cpu_req_ready && !dst_valid && !cpu_cpl_valid, "R1",
            {30'd0, cpu_req_ready, dst_valid}, 32'h2);

        report();
    end

endmodule